// File: doc/BRIEF.md
# Branch and Jump Next-Address Unit

This unit sits beside the execute stage of a 32-bit core that has exactly one architectural delay slot. For each instruction it receives, it decodes the control-transfer class from the opcode, the rt field and the function field, and evaluates the branch condition from the two source register values. It then produces the branch or jump target and, for the linking jumps, a register-write request that carries the return address.

It does not redirect fetch at once. A control instruction loads a one-entry pending register with its resolved continuation address. The next instruction issued is the delay slot. It is reported with that stored address as its successor, and with a redirect flag if the transfer was taken. A control instruction that arrives while a redirect is pending sits in a delay slot and is treated as an ordinary instruction. Cycles with no issue leave the pending entry untouched.

Top module: `redirect_unit`

## Requirements
- R1: After reset no redirect is pending. The first issued instruction reports next_pc = pc + 4 and redirect = 0.
- R2: Opcode 4 is taken when rs_val equals rt_val, and opcode 5 is taken when they differ. The target is pc + 4 + (sign-extended 16-bit offset shifted left by 2), so an offset of 0xFFFC gives pc - 12.
- R3: Opcode 6 is taken when rs_val is zero or negative, and opcode 7 is taken when rs_val is greater than zero. Both compare as 32-bit two's complement.
- R4: Opcode 1 with rt field 0 is taken when rs_val is negative, and with rt field 1 when rs_val is zero or positive. Any other rt field value under opcode 1 is not a control transfer.
- R5: Opcodes 2 and 3 are always taken. Their target is bits 31..28 of pc + 4, followed by the 26-bit index, followed by two zero bits.
- R6: Opcode 0 with function 8 or function 9 is always taken, with target rs_val.
- R7: Opcode 3 requests a link write to register 31. Opcode 0 with function 9 requests a link write to the register named by rd_field. In both cases link_val = pc + 8. No other instruction raises link_we.
- R8: The first instruction issued after a taken control transfer reports next_pc equal to that transfer's target, with redirect = 1.
- R9: The first instruction issued after a control transfer that is not taken reports next_pc = branch pc + 8, with redirect = 0.
- R10: An instruction issued while a redirect is pending is never treated as control. It gives taken = 0 and link_we = 0, and it does not load a new pending entry, so the instruction after it reports pc + 4.
- R11: Cycles with issue_valid low do not consume or change a pending redirect.
- R12: Opcode 4 with both register values zero is taken, which makes it an unconditional branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| pc | input | 32 | Address of the presented instruction |
| opcode | input | 6 | Primary opcode field |
| rt_field | input | 5 | rt field (sub-code under opcode 1) |
| rd_field | input | 5 | rd field (link destination for function 9) |
| funct | input | 6 | Function field under opcode 0 |
| offset | input | 16 | Branch displacement in words |
| index | input | 26 | Jump index |
| rs_val | input | 32 | Value of the rs register |
| rt_val | input | 32 | Value of the rt register |
| taken | output | 1 | Presented instruction is a taken control transfer |
| target | output | 32 | Target of the presented control transfer, 0 otherwise |
| link_we | output | 1 | Link write request |
| link_idx | output | 5 | Link destination register |
| link_val | output | 32 | Return address |
| next_pc | output | 32 | Successor address of the presented instruction |
| redirect | output | 1 | next_pc is a taken transfer target |

## Verification
The bench targets the signed zero comparisons at 0, at -1 and at the most negative value. An unsigned compare would take opcode 7 for negative values. It also targets the backward offset, where a missing sign extension sends the branch far forward, and the jump region bits, which an adder overflow into the index would corrupt. It confirms that the delay slot gets the stored address and not pc + 4, that a control opcode placed in the slot neither links nor re-arms the pending entry, and that idle cycles between a branch and its slot do not drain the pending entry. A wrong REGIMM decode would turn an unknown rt sub-code into a branch. A design that links to pc + 4 would return into its own delay slot.

// File: rtl/redir_pkg.sv
package redir_pkg;
  localparam int AW    = 32;
  localparam int OFFW  = 16;
  localparam int IDXW  = 26;
  localparam int RIDXW = 5;
  localparam int OPW   = 6;
  localparam logic [RIDXW-1:0] LINK_GPR = RIDXW'(31);

  localparam logic [OPW-1:0] OP_SPECIAL = 6'd0;
  localparam logic [OPW-1:0] OP_REGIMM  = 6'd1;
  localparam logic [OPW-1:0] OP_JUMP    = 6'd2;
  localparam logic [OPW-1:0] OP_JLINK   = 6'd3;
  localparam logic [OPW-1:0] OP_BREQ    = 6'd4;
  localparam logic [OPW-1:0] OP_BRNE    = 6'd5;
  localparam logic [OPW-1:0] OP_BRLEZ   = 6'd6;
  localparam logic [OPW-1:0] OP_BRGTZ   = 6'd7;
  localparam logic [OPW-1:0] FN_JREG    = 6'd8;
  localparam logic [OPW-1:0] FN_JREGLNK = 6'd9;
  localparam logic [RIDXW-1:0] RT_LTZ   = 5'd0;
  localparam logic [RIDXW-1:0] RT_GEZ   = 5'd1;

  typedef enum logic [3:0] {
    CK_NONE, CK_EQ, CK_NE, CK_LEZ, CK_GTZ, CK_LTZ, CK_GEZ,
    CK_JMP, CK_JMPL, CK_JREG, CK_JREGL
  } ctl_kind_e;
endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
  import redir_pkg::*;
(
  input  logic [OPW-1:0]   opcode,
  input  logic [RIDXW-1:0] rt_field,
  input  logic [OPW-1:0]   funct,
  output ctl_kind_e        kind
);
  always_comb begin
    kind = CK_NONE;
    unique case (opcode)
      OP_SPECIAL: begin
        if (funct == FN_JREG)         kind = CK_JREG;
        else if (funct == FN_JREGLNK) kind = CK_JREGL;
      end
      OP_REGIMM: begin
        if (rt_field == RT_LTZ)      kind = CK_LTZ;
        else if (rt_field == RT_GEZ) kind = CK_GEZ;
      end
      OP_JUMP:  kind = CK_JMP;
      OP_JLINK: kind = CK_JMPL;
      OP_BREQ:  kind = CK_EQ;
      OP_BRNE:  kind = CK_NE;
      OP_BRLEZ: kind = CK_LEZ;
      OP_BRGTZ: kind = CK_GTZ;
      default:  kind = CK_NONE;
    endcase
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import redir_pkg::*;
#(
  parameter int W = AW
) (
  input  ctl_kind_e      kind,
  input  logic [W-1:0]   rs_val,
  input  logic [W-1:0]   rt_val,
  output logic           taken
);
  logic rs_neg, rs_zero, eq;

  always_comb begin
    rs_neg  = rs_val[W-1];
    rs_zero = (rs_val == '0);
    eq      = (rs_val == rt_val);
    unique case (kind)
      CK_EQ:  taken = eq;
      CK_NE:  taken = !eq;
      CK_LEZ: taken = rs_neg || rs_zero;
      CK_GTZ: taken = !rs_neg && !rs_zero;
      CK_LTZ: taken = rs_neg;
      CK_GEZ: taken = !rs_neg;
      CK_JMP, CK_JMPL, CK_JREG, CK_JREGL: taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/tgt_calc.sv
module tgt_calc
  import redir_pkg::*;
#(
  parameter int W = AW
) (
  input  ctl_kind_e        kind,
  input  logic [W-1:0]     pc,
  input  logic [OFFW-1:0]  offset,
  input  logic [IDXW-1:0]  index,
  input  logic [W-1:0]     rs_val,
  input  logic [RIDXW-1:0] rd_field,
  output logic [W-1:0]     target,
  output logic             link_we,
  output logic [RIDXW-1:0] link_idx,
  output logic [W-1:0]     link_val
);
  localparam int SEXT = W - OFFW - 2;
  localparam int REGB = W - IDXW - 2;

  logic [W-1:0] pc_seq, br_tgt, jmp_tgt;

  always_comb begin
    pc_seq  = pc + W'(4);
    br_tgt  = pc_seq + {{SEXT{offset[OFFW-1]}}, offset, 2'b00};
    jmp_tgt = {pc_seq[W-1 -: REGB], index, 2'b00};
    unique case (kind)
      CK_EQ, CK_NE, CK_LEZ, CK_GTZ, CK_LTZ, CK_GEZ: target = br_tgt;
      CK_JMP, CK_JMPL:   target = jmp_tgt;
      CK_JREG, CK_JREGL: target = rs_val;
      default:           target = '0;
    endcase
    link_we  = (kind == CK_JMPL) || (kind == CK_JREGL);
    link_idx = (kind == CK_JMPL) ? LINK_GPR : rd_field;
    link_val = pc + W'(8);
  end
endmodule

// File: rtl/redirect_unit.sv
module redirect_unit
  import redir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [31:0]      pc,
  input  logic [5:0]       opcode,
  input  logic [4:0]       rt_field,
  input  logic [4:0]       rd_field,
  input  logic [5:0]       funct,
  input  logic [15:0]      offset,
  input  logic [25:0]      index,
  input  logic [31:0]      rs_val,
  input  logic [31:0]      rt_val,
  output logic             taken,
  output logic [31:0]      target,
  output logic             link_we,
  output logic [4:0]       link_idx,
  output logic [31:0]      link_val,
  output logic [31:0]      next_pc,
  output logic             redirect
);
  ctl_kind_e kind_raw, kind_eff;
  logic          pend_v_q, pend_v_d, pend_tk_q, pend_tk_d, pend_en;
  logic [AW-1:0] pend_pc_q, pend_pc_d;

  ctl_decode u_dec (
    .opcode(opcode), .rt_field(rt_field), .funct(funct), .kind(kind_raw)
  );

  // slot instructions and idle cycles are never control
  always_comb kind_eff = (issue_valid && !pend_v_q) ? kind_raw : CK_NONE;

  cond_eval #(.W(AW)) u_cond (
    .kind(kind_eff), .rs_val(rs_val), .rt_val(rt_val), .taken(taken)
  );

  tgt_calc #(.W(AW)) u_tgt (
    .kind(kind_eff), .pc(pc), .offset(offset), .index(index),
    .rs_val(rs_val), .rd_field(rd_field), .target(target),
    .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
  );

  always_comb begin
    pend_en   = issue_valid;
    pend_v_d  = 1'b0;
    pend_tk_d = pend_tk_q;
    pend_pc_d = pend_pc_q;
    if (!pend_v_q && kind_eff != CK_NONE) begin
      pend_v_d  = 1'b1;
      pend_tk_d = taken;
      pend_pc_d = taken ? target : pc + AW'(8);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q  <= 1'b0;
      pend_tk_q <= 1'b0;
      pend_pc_q <= '0;
    end else if (pend_en) begin
      pend_v_q  <= pend_v_d;
      pend_tk_q <= pend_tk_d;
      pend_pc_q <= pend_pc_d;
    end
  end

  always_comb begin
    next_pc  = pend_v_q ? pend_pc_q : pc + AW'(4);
    redirect = issue_valid && pend_v_q && pend_tk_q;
  end

  AST_SLOT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !pend_v_q && kind_raw != CK_NONE) |=> pend_v_q); // R8
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !pend_v_q && taken) |=> (pend_pc_q == $past(target))); // R8
  AST_SLOT_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && pend_v_q) |=> !pend_v_q); // R10
  AST_SLOT_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v_q |-> (!link_we && !taken)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> ($stable(pend_v_q) && $stable(pend_pc_q))); // R11
  AST_LINK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_val == pc + 32'd8)); // R7
endmodule

// File: tb/redirect_unit_test.sv
module redirect_unit_test;
  logic clk = 1'b0;
  logic rst_n;
  logic issue_valid;
  logic [31:0] pc, rs_val, rt_val;
  logic [5:0]  opcode, funct;
  logic [4:0]  rt_field, rd_field;
  logic [15:0] offset;
  logic [25:0] index;
  logic taken, link_we, redirect;
  logic [31:0] target, link_val, next_pc;
  logic [4:0]  link_idx;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  redirect_unit uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .pc(pc),
    .opcode(opcode), .rt_field(rt_field), .rd_field(rd_field), .funct(funct),
    .offset(offset), .index(index), .rs_val(rs_val), .rt_val(rt_val),
    .taken(taken), .target(target), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val), .next_pc(next_pc), .redirect(redirect)
  );

  localparam logic [31:0] BASE = 32'h8002_0000;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [31:0] a, logic [5:0] op, logic [4:0] rt,
                       logic [4:0] rd, logic [5:0] fn, logic [15:0] off,
                       logic [25:0] idx, logic [31:0] rs, logic [31:0] rtv);
    @(negedge clk);
    issue_valid = v; pc = a; opcode = op; rt_field = rt; rd_field = rd;
    funct = fn; offset = off; index = idx; rs_val = rs; rt_val = rtv;
    #1;
  endtask

  // ordinary instruction (opcode 15, not control)
  task automatic plain(logic [31:0] a);
    drive(1'b1, a, 6'd15, 5'd0, 5'd0, 6'd0, 16'h0, 26'h0, 32'h0, 32'h0);
  endtask

  // control instruction followed by its delay slot
  task automatic ctl(string tag, logic [31:0] a, logic [5:0] op, logic [4:0] rt,
                     logic [4:0] rd, logic [5:0] fn, logic [15:0] off,
                     logic [25:0] idx, logic [31:0] rs, logic [31:0] rtv,
                     logic exp_tk, logic [31:0] exp_tgt, logic exp_lwe,
                     logic [4:0] exp_lidx);
    drive(1'b1, a, op, rt, rd, fn, off, idx, rs, rtv);
    chk({tag, " taken"}, 32'(taken), 32'(exp_tk));
    if (exp_tk) chk({tag, " target"}, target, exp_tgt);
    chk({tag, " R7 link_we"}, 32'(link_we), 32'(exp_lwe));
    if (exp_lwe) begin
      chk({tag, " R7 link_idx"}, 32'(link_idx), 32'(exp_lidx));
      chk({tag, " R7 link_val"}, link_val, a + 32'd8);
    end
    plain(a + 32'd4);
    chk({tag, " R8/R9 slot next_pc"}, next_pc, exp_tk ? exp_tgt : a + 32'd8);
    chk({tag, " R8/R9 slot redirect"}, 32'(redirect), 32'(exp_tk));
  endtask

  task automatic t_reset();
    plain(BASE);
    chk("R1 next_pc", next_pc, BASE + 32'd4);
    chk("R1 redirect", 32'(redirect), 32'd0);
  endtask

  task automatic t_equal();
    ctl("R2 eq taken", BASE, 6'd4, 5'd16, 5'd0, 6'd0, 16'd61, 26'd0,
        32'hFFFF_FFEA, 32'hFFFF_FFEA, 1'b1, 32'h8002_00F8, 1'b0, 5'd0);
    ctl("R2 eq back", BASE, 6'd4, 5'd16, 5'd0, 6'd0, 16'hFFFC, 26'd0,
        32'd5, 32'd5, 1'b1, 32'h8001_FFF4, 1'b0, 5'd0);
    ctl("R9 eq not", BASE, 6'd4, 5'd0, 5'd0, 6'd0, 16'd61, 26'd0,
        32'd5, 32'd6, 1'b0, 32'd0, 1'b0, 5'd0);
    ctl("R2 ne taken", BASE, 6'd5, 5'd0, 5'd0, 6'd0, 16'd61, 26'd0,
        32'hFFFF_FFEA, 32'd22, 1'b1, 32'h8002_00F8, 1'b0, 5'd0);
    ctl("R2 ne not", BASE, 6'd5, 5'd0, 5'd0, 6'd0, 16'd61, 26'd0,
        32'd7, 32'd7, 1'b0, 32'd0, 1'b0, 5'd0);
    ctl("R12 uncond", BASE, 6'd4, 5'd0, 5'd0, 6'd0, 16'd3, 26'd0,
        32'd0, 32'd0, 1'b1, BASE + 32'd16, 1'b0, 5'd0);
  endtask

  task automatic t_signed();
    ctl("R3 lez zero", BASE, 6'd6, 5'd0, 5'd0, 6'd0, 16'd1, 26'd0,
        32'd0, 32'd0, 1'b1, BASE + 32'd8, 1'b0, 5'd0);
    ctl("R3 lez min", BASE, 6'd6, 5'd0, 5'd0, 6'd0, 16'd1, 26'd0,
        32'h8000_0000, 32'd0, 1'b1, BASE + 32'd8, 1'b0, 5'd0);
    ctl("R3 lez pos", BASE, 6'd6, 5'd0, 5'd0, 6'd0, 16'd1, 26'd0,
        32'd1, 32'd0, 1'b0, 32'd0, 1'b0, 5'd0);
    ctl("R3 gtz pos", BASE, 6'd7, 5'd0, 5'd0, 6'd0, 16'd1, 26'd0,
        32'd22, 32'd0, 1'b1, BASE + 32'd8, 1'b0, 5'd0);
    ctl("R3 gtz neg", BASE, 6'd7, 5'd0, 5'd0, 6'd0, 16'd1, 26'd0,
        32'hFFFF_FFFF, 32'd0, 1'b0, 32'd0, 1'b0, 5'd0);
    ctl("R3 gtz zero", BASE, 6'd7, 5'd0, 5'd0, 6'd0, 16'd1, 26'd0,
        32'd0, 32'd0, 1'b0, 32'd0, 1'b0, 5'd0);
  endtask

  task automatic t_regimm();
    ctl("R4 ltz neg", BASE, 6'd1, 5'd0, 5'd0, 6'd0, 16'd61, 26'd0,
        32'hFFFF_FFEA, 32'd0, 1'b1, 32'h8002_00F8, 1'b0, 5'd0);
    ctl("R4 ltz zero", BASE, 6'd1, 5'd0, 5'd0, 6'd0, 16'd61, 26'd0,
        32'd0, 32'd0, 1'b0, 32'd0, 1'b0, 5'd0);
    ctl("R4 gez zero", BASE, 6'd1, 5'd1, 5'd0, 6'd0, 16'd61, 26'd0,
        32'd0, 32'd0, 1'b1, 32'h8002_00F8, 1'b0, 5'd0);
    ctl("R4 gez neg", BASE, 6'd1, 5'd1, 5'd0, 6'd0, 16'd61, 26'd0,
        32'h8000_0000, 32'd0, 1'b0, 32'd0, 1'b0, 5'd0);
    // unknown sub-code: not control, next instruction is not a slot
    drive(1'b1, BASE, 6'd1, 5'd2, 5'd0, 6'd0, 16'd61, 26'd0, 32'd5, 32'd0);
    chk("R4 other rt taken", 32'(taken), 32'd0);
    plain(BASE + 32'd4);
    chk("R4 other rt next_pc", next_pc, BASE + 32'd8);
    chk("R4 other rt redirect", 32'(redirect), 32'd0);
  endtask

  task automatic t_jumps();
    ctl("R5 j", BASE, 6'd2, 5'd0, 5'd0, 6'd0, 16'd0, 26'd24,
        32'd0, 32'd0, 1'b1, 32'h8000_0060, 1'b0, 5'd0);
    ctl("R5 jal", 32'h7FFF_FFFC, 6'd3, 5'd0, 5'd0, 6'd0, 16'd0, 26'h3FF_FFFF,
        32'd0, 32'd0, 1'b1, 32'h8FFF_FFFC, 1'b1, 5'd31);
    ctl("R6 jr", BASE, 6'd0, 5'd0, 5'd0, 6'd8, 16'd0, 26'd0,
        32'h8004_0000, 32'd0, 1'b1, 32'h8004_0000, 1'b0, 5'd0);
    ctl("R6 jalr", BASE, 6'd0, 5'd0, 5'd13, 6'd9, 16'd0, 26'd0,
        32'h8002_0058, 32'd0, 1'b1, 32'h8002_0058, 1'b1, 5'd13);
    drive(1'b1, BASE, 6'd0, 5'd0, 5'd13, 6'd32, 16'd0, 26'd0, 32'd1, 32'd2);
    chk("R7 alu no link", 32'(link_we), 32'd0);
  endtask

  task automatic t_slot_ctl();
    drive(1'b1, BASE, 6'd2, 5'd0, 5'd0, 6'd0, 16'd0, 26'd100, 32'd0, 32'd0);
    // jump-and-link placed in the delay slot
    drive(1'b1, BASE + 32'd4, 6'd3, 5'd0, 5'd0, 6'd0, 16'd0, 26'd7, 32'd0, 32'd0);
    chk("R10 slot taken", 32'(taken), 32'd0);
    chk("R10 slot link_we", 32'(link_we), 32'd0);
    chk("R10 slot next_pc", next_pc, 32'h8000_0190);
    plain(32'h8000_0190);
    chk("R10 after slot next_pc", next_pc, 32'h8000_0194);
    chk("R10 after slot redirect", 32'(redirect), 32'd0);
  endtask

  task automatic t_idle();
    drive(1'b1, BASE, 6'd4, 5'd0, 5'd0, 6'd0, 16'd10, 26'd0, 32'd3, 32'd3);
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 32'h1234_0000, 6'd2, 5'd0, 5'd0, 6'd0, 16'd0, 26'd5, 32'd0, 32'd0);
      chk("R11 idle redirect", 32'(redirect), 32'd0);
    end
    plain(BASE + 32'd4);
    chk("R11 held next_pc", next_pc, BASE + 32'd44);
    chk("R11 held redirect", 32'(redirect), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    issue_valid = 1'b0; pc = '0; opcode = '0; rt_field = '0; rd_field = '0;
    funct = '0; offset = '0; index = '0; rs_val = '0; rt_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_equal();
    t_signed();
    t_regimm();
    t_jumps();
    t_slot_ctl();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule